// File: doc/BRIEF.md
# Message-Interrupt Configuration and Enable Gate

This block keeps one configuration byte for each interrupt ID in a contiguous window of message-signalled interrupt IDs. By default the window starts at 8192 and holds 64 IDs. Software writes the bytes through a byte-lane write port. Each byte holds an enable flag and a six-bit priority. Interrupts arrive on a valid/ready port as full-width IDs.

An arrival inside the window marks its ID pending. Every pending ID whose enable flag is set competes for a single registered delivery slot. The slot offers the ID and its priority on a valid/ready output port.

A pending ID that is disabled stays pending, however long that lasts. It is offered as soon as a later configuration write sets its enable flag. An arrival outside the window is dropped and flagged with a one-cycle error pulse.

Top module: `irq_cfg_gate`

## Requirements
- R1: After reset every ID is disabled with priority 0x00, nothing is pending, `dlv_valid` and `err_pulse` are low, and an arrival on an unconfigured ID is not delivered until a write enables it, at which point it is offered with priority 0x00.
- R2: The configuration byte for interrupt ID `BASE_ID + n` is written at byte offset `n`. Bit 0 of that byte is the enable flag (1 = enabled, 0 = disabled).
- R3: The priority presented on `dlv_prio` is the configuration byte with bits 1 and 0 forced to zero (byte AND 0xFC).
- R4: An arrival on an enabled ID accepted at clock edge k, with the slot empty, raises `dlv_valid` with that ID after edge k+1. The delivered ID always lies inside the window.
- R5: An arrival on a disabled ID is held pending and not offered. It is offered after a later write sets its enable flag: the write at edge w is followed by `dlv_valid` after edge w+1.
- R6: Write lane k (data bits 8k+7..8k, byte enable bit k) updates the ID at offset `cfg_wr_off + k`. Lanes are independent. A lane whose enable bit is 0 leaves its ID unchanged, and a lane whose offset falls past the window changes nothing.
- R7: An ID that arrives again while it is still pending and not yet offered is delivered only once.
- R8: When several enabled pending IDs compete, the one with the lowest priority value is offered first. Among equal priorities, the lowest ID goes first.
- R9: An arrival below `BASE_ID` or at or above `BASE_ID + NUM_IDS` is dropped. `err_pulse` is high for exactly the cycle after the accepting edge.
- R10: While `dlv_valid` is high and `dlv_ready` is low, `dlv_valid`, `dlv_id` and `dlv_prio` hold their values.
- R11: `irq_ready` is high in every cycle after the first clock edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_off | input | OFF_W | Byte offset of lane 0 from the window base |
| cfg_wr_data | input | 8*LANES | Write data, one byte per lane |
| cfg_wr_be | input | LANES | Per-lane byte enables |
| irq_valid | input | 1 | Arrival valid |
| irq_ready | output | 1 | Arrival ready |
| irq_id | input | ID_W | Arriving interrupt ID |
| dlv_valid | output | 1 | Delivery slot holds an ID |
| dlv_ready | input | 1 | Consumer takes the delivery |
| dlv_id | output | ID_W | Delivered interrupt ID |
| dlv_prio | output | 8 | Delivered priority (low two bits zero) |
| err_pulse | output | 1 | One-cycle pulse for an out-of-window arrival |

## Verification
The assertions assume that the consumer obeys the delivery handshake and that the arrival port carries full-width IDs. They do not constrain the write offset, since lanes past the window must be harmless.

The stimulus changes inputs one nanosecond after the rising edge, so every input is stable for a full cycle. It keeps `dlv_ready` high except in the stall scenario. It never sends the ID that is being loaded into the slot in that same cycle, so pending state is always set or cleared unambiguously.

// File: rtl/icg_pkg.sv
package icg_pkg;

  // Priority field of a configuration byte: low two bits carry no priority.
  function automatic logic [7:0] cfg_prio(input logic [7:0] cfg_byte);
    return cfg_byte & 8'hFC;
  endfunction

  // Enable flag of a configuration byte.
  function automatic logic cfg_enabled(input logic [7:0] cfg_byte);
    return cfg_byte[0];
  endfunction

  // True when an ID lies in [base, base + count).
  function automatic logic id_in_window(input logic [63:0] id,
                                        input logic [63:0] base,
                                        input logic [63:0] count);
    return (id >= base) && (id < base + count);
  endfunction

  // True when write lane `lane` starting at `offset` lands on slot `slot`.
  function automatic logic lane_hits(input logic [31:0] offset,
                                     input logic [31:0] lane,
                                     input logic [31:0] slot);
    return (offset + lane) == slot;
  endfunction

endpackage

// File: rtl/icg_cfg_store.sv
module icg_cfg_store
  import icg_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int OFF_W   = 16,
  parameter int LANES   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [OFF_W-1:0]          wr_off,
  input  logic [8*LANES-1:0]        wr_data,
  input  logic [LANES-1:0]          wr_be,
  output logic [NUM_IDS-1:0]        en_vec,
  output logic [NUM_IDS-1:0][7:0]   prio_vec
);

  // One configuration byte per ID; lanes past the window match no slot.
  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    logic [7:0] cfg_q;
    logic       hit;
    logic [7:0] wbyte;

    always_comb begin
      hit   = 1'b0;
      wbyte = 8'h00;
      for (int k = 0; k < LANES; k++) begin
        if (wr_be[k] && lane_hits(32'(wr_off), 32'(k), 32'(g))) begin
          hit   = 1'b1;
          wbyte = wr_data[8*k +: 8];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q <= 8'h00;
      else if (wr_en && hit)
        cfg_q <= wbyte;
    end

    assign en_vec[g]   = cfg_enabled(cfg_q);
    assign prio_vec[g] = cfg_prio(cfg_q);
  end

endmodule

// File: rtl/icg_pend_track.sv
module icg_pend_track #(
  parameter int NUM_IDS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IDS-1:0] set_vec,
  input  logic [NUM_IDS-1:0] clr_vec,
  output logic [NUM_IDS-1:0] pend_vec
);

  // Set wins over clear: a fresh arrival during a load is a new event.
  // Setting an already pending bit changes nothing, so duplicates merge.
  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_vec <= '0;
    else
      pend_vec <= (pend_vec & ~clr_vec) | set_vec;
  end

endmodule

// File: rtl/icg_prio_arb.sv
module icg_prio_arb #(
  parameter int NUM_IDS = 64,
  parameter int IDX_W   = 6
) (
  input  logic [NUM_IDS-1:0]      cand_vec,
  input  logic [NUM_IDS-1:0][7:0] prio_vec,
  output logic                    win_any,
  output logic [IDX_W-1:0]        win_idx,
  output logic [NUM_IDS-1:0]      grant_vec
);

  logic [7:0] best;

  // Ascending scan with strict compare: lowest value wins, ties to lowest index.
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    best    = 8'hFF;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (cand_vec[i] && (!win_any || prio_vec[i] < best)) begin
        win_any = 1'b1;
        win_idx = IDX_W'(i);
        best    = prio_vec[i];
      end
    end
  end

  always_comb begin
    grant_vec = '0;
    if (win_any) grant_vec[win_idx] = 1'b1;
  end

endmodule

// File: rtl/irq_cfg_gate.sv
module irq_cfg_gate
  import icg_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int BASE_ID = 8192,
  parameter int ID_W    = 32,
  parameter int LANES   = 4,
  parameter int OFF_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [OFF_W-1:0]   cfg_wr_off,
  input  logic [8*LANES-1:0] cfg_wr_data,
  input  logic [LANES-1:0]   cfg_wr_be,
  input  logic               irq_valid,
  output logic               irq_ready,
  input  logic [ID_W-1:0]    irq_id,
  output logic               dlv_valid,
  input  logic               dlv_ready,
  output logic [ID_W-1:0]    dlv_id,
  output logic [7:0]         dlv_prio,
  output logic               err_pulse
);

  localparam int IDX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;

  // Named internal events, brought out for the checker.
  logic                    arr_accept;
  logic                    arr_in_win;
  logic [IDX_W-1:0]        arr_idx;
  logic [NUM_IDS-1:0]      set_vec;
  logic [NUM_IDS-1:0]      clr_vec;
  logic [NUM_IDS-1:0]      pend_vec;
  logic [NUM_IDS-1:0]      en_vec;
  logic [NUM_IDS-1:0][7:0] prio_vec;
  logic [NUM_IDS-1:0]      cand_vec;
  logic [NUM_IDS-1:0]      grant_vec;
  logic                    win_any;
  logic [IDX_W-1:0]        win_idx;
  logic                    slot_free;
  logic                    slot_load;

  // Arrival side
  always_ff @(posedge clk) begin
    if (!rst_n) irq_ready <= 1'b0;
    else        irq_ready <= 1'b1;
  end

  assign arr_accept = irq_valid && irq_ready;
  assign arr_in_win = id_in_window(64'(irq_id), 64'(BASE_ID), 64'(NUM_IDS));
  assign arr_idx    = IDX_W'(irq_id - ID_W'(BASE_ID));

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_set
    assign set_vec[g] = arr_accept && arr_in_win && (32'(arr_idx) == 32'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= arr_accept && !arr_in_win;
  end

  // Configuration bytes
  icg_cfg_store #(
    .NUM_IDS (NUM_IDS),
    .OFF_W   (OFF_W),
    .LANES   (LANES)
  ) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_off   (cfg_wr_off),
    .wr_data  (cfg_wr_data),
    .wr_be    (cfg_wr_be),
    .en_vec   (en_vec),
    .prio_vec (prio_vec)
  );

  // Pending state
  icg_pend_track #(
    .NUM_IDS (NUM_IDS)
  ) i_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .pend_vec (pend_vec)
  );

  // Enable gate and selection
  assign cand_vec = pend_vec & en_vec;

  icg_prio_arb #(
    .NUM_IDS (NUM_IDS),
    .IDX_W   (IDX_W)
  ) i_arb (
    .cand_vec  (cand_vec),
    .prio_vec  (prio_vec),
    .win_any   (win_any),
    .win_idx   (win_idx),
    .grant_vec (grant_vec)
  );

  // Delivery slot: an ID leaves the pending set when it enters the slot.
  assign slot_free = !dlv_valid || dlv_ready;
  assign slot_load = slot_free && win_any;
  assign clr_vec   = slot_load ? grant_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid <= 1'b0;
      dlv_id    <= '0;
      dlv_prio  <= 8'h00;
    end else if (slot_load) begin
      dlv_valid <= 1'b1;
      dlv_id    <= ID_W'(BASE_ID) + ID_W'(win_idx);
      dlv_prio  <= prio_vec[win_idx];
    end else if (dlv_ready) begin
      dlv_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_cfg_gate_chk.sv
module irq_cfg_gate_chk #(
  parameter int NUM_IDS = 64,
  parameter int BASE_ID = 8192,
  parameter int ID_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_valid,
  input logic               irq_ready,
  input logic [ID_W-1:0]    irq_id,
  input logic               dlv_valid,
  input logic               dlv_ready,
  input logic [ID_W-1:0]    dlv_id,
  input logic [7:0]         dlv_prio,
  input logic               err_pulse,
  input logic [NUM_IDS-1:0] grant_vec,
  input logic [NUM_IDS-1:0] cand_vec
);

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(irq_valid && irq_ready &&
      (64'(irq_id) < 64'(BASE_ID) || 64'(irq_id) >= 64'(BASE_ID) + 64'(NUM_IDS)))); // R9

  AST_DLV_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (64'(dlv_id) >= 64'(BASE_ID) &&
                   64'(dlv_id) <  64'(BASE_ID) + 64'(NUM_IDS))); // R4

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_id) && $stable(dlv_prio))); // R10

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec)); // R8

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~cand_vec) == '0); // R5

  AST_PRIO_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (dlv_prio[1:0] == 2'b00)); // R3

endmodule

bind irq_cfg_gate irq_cfg_gate_chk #(
  .NUM_IDS (NUM_IDS),
  .BASE_ID (BASE_ID),
  .ID_W    (ID_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_valid (irq_valid),
  .irq_ready (irq_ready),
  .irq_id    (irq_id),
  .dlv_valid (dlv_valid),
  .dlv_ready (dlv_ready),
  .dlv_id    (dlv_id),
  .dlv_prio  (dlv_prio),
  .err_pulse (err_pulse),
  .grant_vec (grant_vec),
  .cand_vec  (cand_vec)
);

// File: tb/test_irq_cfg_gate.sv
`timescale 1ns/1ps
module test_irq_cfg_gate;

  localparam int NUM_IDS = 64;
  localparam int BASE    = 8192;
  localparam int ID_W    = 32;
  localparam int LANES   = 4;
  localparam int OFF_W   = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_wr_en = 1'b0;
  logic [OFF_W-1:0]   cfg_wr_off = '0;
  logic [8*LANES-1:0] cfg_wr_data = '0;
  logic [LANES-1:0]   cfg_wr_be = '0;
  logic               irq_valid = 1'b0;
  logic               irq_ready;
  logic [ID_W-1:0]    irq_id = '0;
  logic               dlv_valid;
  logic               dlv_ready = 1'b1;
  logic [ID_W-1:0]    dlv_id;
  logic [7:0]         dlv_prio;
  logic               err_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  int log_id   [64];
  int log_prio [64];
  int log_n = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_cfg_gate #(
    .NUM_IDS (NUM_IDS), .BASE_ID (BASE), .ID_W (ID_W),
    .LANES (LANES), .OFF_W (OFF_W)
  ) i_irq_cfg_gate (
    .clk (clk), .rst_n (rst_n),
    .cfg_wr_en (cfg_wr_en), .cfg_wr_off (cfg_wr_off),
    .cfg_wr_data (cfg_wr_data), .cfg_wr_be (cfg_wr_be),
    .irq_valid (irq_valid), .irq_ready (irq_ready), .irq_id (irq_id),
    .dlv_valid (dlv_valid), .dlv_ready (dlv_ready),
    .dlv_id (dlv_id), .dlv_prio (dlv_prio), .err_pulse (err_pulse)
  );

  // Transfer log: a transfer completes at the next rising edge.
  always @(negedge clk) begin
    if (rst_n && dlv_valid && dlv_ready && log_n < 64) begin
      log_id[log_n]   = int'(dlv_id);
      log_prio[log_n] = int'(dlv_prio);
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input int off, input logic [31:0] data, input logic [3:0] be);
    cfg_wr_en = 1'b1; cfg_wr_off = OFF_W'(off); cfg_wr_data = data; cfg_wr_be = be;
    cycles(1);
    cfg_wr_en = 1'b0; cfg_wr_be = '0;
  endtask

  task automatic cfg_byte(input int off, input logic [7:0] b);
    cfg_write(off, {24'h0, b}, 4'b0001);
  endtask

  task automatic send(input int id);
    irq_valid = 1'b1; irq_id = ID_W'(id);
    cycles(1);
    irq_valid = 1'b0;
  endtask

  task automatic clear_log();
    log_n = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(dlv_valid == 1'b0, "R1 dlv_valid in reset", int'(dlv_valid), 0);
    check(err_pulse == 1'b0, "R1 err_pulse in reset", int'(err_pulse), 0);
    rst_n = 1'b1;
    cycles(1);
    @(negedge clk);
    check(irq_ready == 1'b1, "R11 irq_ready after reset", int'(irq_ready), 1);
    clear_log();
    send(BASE + 60);
    cycles(6);
    check(log_n == 0, "R1 unconfigured ID not delivered", log_n, 0);
    cfg_byte(60, 8'h01);
    cycles(3);
    check(log_n == 1 && log_id[0] == BASE + 60, "R1 held ID delivered on enable", log_id[0], BASE + 60);
    check(log_prio[0] == 0, "R1 reset priority zero", log_prio[0], 0);
  endtask

  task automatic t_basic_timing();
    cfg_byte(5, 8'hA5);
    clear_log();
    send(BASE + 5);
    @(negedge clk);
    check(dlv_valid == 1'b0, "R4 not valid one cycle after accept", int'(dlv_valid), 0);
    @(negedge clk);
    check(dlv_valid == 1'b1 && dlv_id == ID_W'(BASE + 5), "R4 offered after second edge", int'(dlv_id), BASE + 5);
    check(dlv_prio == 8'hA4, "R2 R3 priority from byte offset 5", int'(dlv_prio), 'hA4);
    cycles(3);
    check(log_n == 1, "R4 exactly one transfer", log_n, 1);
  endtask

  task automatic t_prio_mask();
    cfg_byte(7, 8'h03);
    cfg_byte(8, 8'hFF);
    clear_log();
    send(BASE + 7);
    send(BASE + 8);
    cycles(4);
    check(log_n == 2 && log_prio[0] == 'h00, "R3 byte 0x03 gives 0x00", log_prio[0], 'h00);
    check(log_prio[1] == 'hFC, "R3 byte 0xFF gives 0xFC", log_prio[1], 'hFC);
  endtask

  task automatic t_multi_lane();
    cfg_byte(12, 8'h21);
    cfg_write(10, 32'h41_77_C1_81, 4'b1011);
    clear_log();
    send(BASE + 10); send(BASE + 11); send(BASE + 12); send(BASE + 13);
    cycles(4);
    check(log_n == 4, "R6 four transfers", log_n, 4);
    check(log_id[0] == BASE + 10 && log_prio[0] == 'h80, "R6 lane0 id10", log_prio[0], 'h80);
    check(log_id[1] == BASE + 11 && log_prio[1] == 'hC0, "R6 lane1 id11", log_prio[1], 'hC0);
    check(log_id[2] == BASE + 12 && log_prio[2] == 'h20, "R6 lane2 masked id12 unchanged", log_prio[2], 'h20);
    check(log_id[3] == BASE + 13 && log_prio[3] == 'h40, "R6 lane3 id13", log_prio[3], 'h40);
    // Lanes 2 and 3 fall past the window; ID 0 must stay disabled.
    cfg_write(62, 32'h55_55_09_05, 4'b1111);
    clear_log();
    send(BASE + 0);
    cycles(4);
    check(log_n == 0, "R6 lanes past window do not touch id0", log_n, 0);
    send(BASE + 62); send(BASE + 63);
    cycles(4);
    check(log_n == 2 && log_prio[0] == 'h04 && log_prio[1] == 'h08, "R6 ids 62 63 written", log_prio[1], 'h08);
  endtask

  task automatic t_disabled_hold();
    cfg_byte(20, 8'h40);
    clear_log();
    send(BASE + 20);
    cycles(6);
    check(log_n == 0, "R5 disabled ID held", log_n, 0);
    cfg_byte(20, 8'h41);
    @(negedge clk);
    check(dlv_valid == 1'b0, "R5 not valid right after enabling write", int'(dlv_valid), 0);
    @(negedge clk);
    check(dlv_valid == 1'b1 && dlv_id == ID_W'(BASE + 20), "R5 offered after enable", int'(dlv_id), BASE + 20);
    cycles(3);
    check(log_n == 1 && log_prio[0] == 'h40, "R5 delivered priority", log_prio[0], 'h40);
  endtask

  task automatic t_duplicate();
    cfg_byte(30, 8'h10);
    clear_log();
    send(BASE + 30);
    send(BASE + 30);
    cycles(2);
    cfg_byte(30, 8'h11);
    cycles(6);
    check(log_n == 1, "R7 duplicate delivered once", log_n, 1);
  endtask

  task automatic t_arbitration();
    clear_log();
    send(BASE + 40); send(BASE + 41); send(BASE + 42); send(BASE + 43);
    cycles(3);
    check(log_n == 0, "R8 all held before enable", log_n, 0);
    cfg_write(40, 32'hC1_41_41_81, 4'b1111);
    cycles(6);
    check(log_n == 4, "R8 four transfers", log_n, 4);
    check(log_id[0] == BASE + 41, "R8 first lowest prio lowest id", log_id[0], BASE + 41);
    check(log_id[1] == BASE + 42, "R8 second tie partner", log_id[1], BASE + 42);
    check(log_id[2] == BASE + 40, "R8 third", log_id[2], BASE + 40);
    check(log_id[3] == BASE + 43, "R8 last highest value", log_id[3], BASE + 43);
  endtask

  task automatic t_stall();
    cfg_byte(50, 8'h31);
    clear_log();
    dlv_ready = 1'b0;
    send(BASE + 50);
    @(negedge clk); @(negedge clk);
    check(dlv_valid == 1'b1 && dlv_id == ID_W'(BASE + 50), "R10 offered while stalled", int'(dlv_id), BASE + 50);
    cycles(4);
    @(negedge clk);
    check(dlv_valid == 1'b1 && dlv_id == ID_W'(BASE + 50) && dlv_prio == 8'h30, "R10 held under stall", int'(dlv_prio), 'h30);
    check(log_n == 0, "R10 no transfer while stalled", log_n, 0);
    cycles(1);
    dlv_ready = 1'b1;
    cycles(3);
    check(log_n == 1, "R10 one transfer after release", log_n, 1);
  endtask

  task automatic t_out_of_range();
    clear_log();
    send(BASE - 1);
    @(negedge clk);
    check(err_pulse == 1'b1, "R9 error pulse below window", int'(err_pulse), 1);
    @(negedge clk);
    check(err_pulse == 1'b0, "R9 error pulse one cycle", int'(err_pulse), 0);
    send(BASE + NUM_IDS);
    @(negedge clk);
    check(err_pulse == 1'b1, "R9 error pulse above window", int'(err_pulse), 1);
    cycles(4);
    check(log_n == 0, "R9 out-of-window dropped", log_n, 0);
  endtask

  initial begin
    cycles(3);
    t_reset();
    t_basic_timing();
    t_prio_mask();
    t_multi_lane();
    t_disabled_hold();
    t_duplicate();
    t_arbitration();
    t_stall();
    t_out_of_range();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule